// File: doc/BRIEF.md
# DMA Bus Handshake Sequencer

This block runs the bus-ownership handshake and the transfer timing for one DMA channel. When the channel is armed and its peripheral raises a request, the block asks the processor for the bus. It waits in a holding state until the processor grants the bus, and then acknowledges the peripheral. Each transfer steps through four working states. After the third working state, wait states are added for as long as the ready input is low. A memory-to-memory transfer runs the four working states twice: once for a read phase and once for a write phase.

The transfer mode decides when the bus is handed back. Single mode gives the bus back after every transfer and needs a fresh request edge for the next one. Block mode keeps the bus until a terminal-count input arrives, and that count also disarms the channel. Demand mode keeps the bus for as long as the peripheral holds its request. Address and count registers, the arbitration between channels and the programming interface sit in other blocks. The terminal count is an input from an external counter unit.

Top module: `dmaSequencer`

## Requirements
- R1: While the channel is not armed, or no request is present, the sequencer stays idle: stateCode is 0, and busReq and devAck are low.
- R2: An armed request sampled at a clock edge in idle moves the sequencer to the hold state (stateCode 1), which raises busReq. It stays in the hold state with devAck low until busGrant is sampled high, and then moves to S1 (stateCode 2).
- R3: A transfer with no waits visits S1, S2, S3 and S4 (stateCode 2, 3, 4, 6) in that order, one cycle each. devAck is high for exactly those 4 cycles.
- R4: ready is sampled at the end of S3 and at the end of each wait state. While it is low, wait states (stateCode 5) are inserted before S4, so a transfer with n waits holds devAck for 4+n cycles.
- R5: In single mode (xferMode 0, or 3), each request assertion gives exactly one transfer. busReq falls in the cycle after S4, and no new bus request is made until devReq has been low for at least one edge.
- R6: In block mode (xferMode 1), transfers run back to back with devAck held high and devReq ignored, until termCount is sampled high at the end of a final S4. N transfers hold devAck for 4N cycles.
- R7: A block-mode tenure that ends on terminal count clears chanArmed.
- R8: In demand mode (xferMode 2), a new transfer starts after S4 while devReq stays high. The tenure ends when devReq is low, or termCount is high, at the end of S4, and chanArmed is kept.
- R9: With memToMem high, each transfer runs S1 to S4 twice. writePhase is high during the second pass, so one transfer holds devAck for 8 cycles with no waits.
- R10: An armSet pulse arms the channel and an armClr pulse disarms it; armClr wins over armSet. A disarmed channel ignores devReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| armSet | input | 1 | pulse that arms the channel |
| armClr | input | 1 | pulse that disarms the channel |
| xferMode | input | 2 | 0 single, 1 block, 2 demand, 3 single |
| memToMem | input | 1 | two-pass (read then write) transfers |
| devReq | input | 1 | peripheral service request |
| busGrant | input | 1 | processor hold acknowledge |
| ready | input | 1 | low stretches the transfer with wait states |
| termCount | input | 1 | terminal count from the counter unit |
| busReq | output | 1 | bus hold request to the processor |
| devAck | output | 1 | acknowledge to the peripheral |
| chanArmed | output | 1 | channel enable state |
| writePhase | output | 1 | second pass of a memory-to-memory transfer |
| stateCode | output | 3 | current sequencer state |

## Verification
Every output is decoded from registered state, so each output moves one edge after the input sampled at that edge. busReq rises in the cycle after an armed request. S1 follows the edge that samples busGrant high, and busReq and devAck fall in the cycle after the final S4. The bench changes inputs and reads outputs only on falling edges. It raises termCount, lowers devReq and lowers ready on the falling edge inside the state whose closing edge should act on them. It then compares exact devAck cycle totals per tenure (4, 4+n, 4N, 8) against values worked out from the requirements.

// File: rtl/dmaSeqPkg.sv
package dmaSeqPkg;
  localparam int STATE_W = 3;
  localparam int MODE_W  = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_SI = 3'd0, ST_S0 = 3'd1, ST_S1 = 3'd2, ST_S2 = 3'd3,
    ST_S3 = 3'd4, ST_SW = 3'd5, ST_S4 = 3'd6
  } seqState_e;

  localparam logic [MODE_W-1:0] MODE_SINGLE = 2'd0;
  localparam logic [MODE_W-1:0] MODE_BLOCK  = 2'd1;
  localparam logic [MODE_W-1:0] MODE_DEMAND = 2'd2;

  typedef struct packed {
    logic startTenure;
    logic enterWrite;
    logic xferEnd;
    logic singleDone;
    logic blockDone;
  } seqStrobe_t;
endpackage

// File: rtl/dmaSeqCtrl.sv
module dmaSeqCtrl
  import dmaSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] xferMode,
  input  logic              memToMem,
  input  logic              devReq,
  input  logic              busGrant,
  input  logic              ready,
  input  logic              termCount,
  input  logic              armed,
  input  logic              holdOff,
  input  logic              inWrite,
  output seqState_e         state,
  output seqStrobe_t        strobe,
  output logic              busReq,
  output logic              devAck
);
  seqState_e nextState;
  logic lastPass;

  assign lastPass = !memToMem || inWrite;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_SI: if (armed && devReq && !holdOff) begin
        nextState          = ST_S0;
        strobe.startTenure = 1'b1;
      end
      ST_S0: if (busGrant) nextState = ST_S1;
      ST_S1: nextState = ST_S2;
      ST_S2: nextState = ST_S3;
      ST_S3, ST_SW: nextState = ready ? ST_S4 : ST_SW;
      ST_S4: begin
        if (!lastPass) begin
          nextState         = ST_S1;
          strobe.enterWrite = 1'b1;
        end else begin
          strobe.xferEnd = 1'b1;
          case (xferMode)
            MODE_BLOCK: begin
              nextState        = termCount ? ST_SI : ST_S1;
              strobe.blockDone = termCount;
            end
            MODE_DEMAND: nextState = (devReq && !termCount) ? ST_S1 : ST_SI;
            default: begin
              nextState         = ST_SI;
              strobe.singleDone = 1'b1;
            end
          endcase
        end
      end
      default: nextState = ST_SI;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SI;
    else       state <= nextState;
  end

  assign busReq = (state != ST_SI);
  assign devAck = (state != ST_SI) && (state != ST_S0);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SI && !armed) |=> (state == ST_SI));
  assert_grant_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S0 && !busGrant) |=> (state == ST_S0 && !devAck));
  assert_order_s1_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S1) |=> (state == ST_S2));
  assert_order_s2_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S2) |=> (state == ST_S3));
  assert_wait_stretch_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_S3 || state == ST_SW) && !ready) |=> (state == ST_SW && devAck));
endmodule

// File: rtl/dmaSeqData.sv
module dmaSeqData
  import dmaSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       armSet,
  input  logic       armClr,
  input  logic       devReq,
  input  seqStrobe_t strobe,
  output logic       armed,
  output logic       holdOff,
  output logic       inWrite
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      holdOff <= 1'b0;
      inWrite <= 1'b0;
    end else begin
      if (armClr || strobe.blockDone) armed <= 1'b0;
      else if (armSet)                armed <= 1'b1;

      if (strobe.singleDone) holdOff <= 1'b1;
      else if (!devReq)      holdOff <= 1'b0;

      if (strobe.xferEnd || strobe.startTenure) inWrite <= 1'b0;
      else if (strobe.enterWrite)               inWrite <= 1'b1;
    end
  end

  assert_single_holdoff_R5: assert property (@(posedge clk) disable iff (!rstN)
    (holdOff && devReq && !strobe.singleDone) |=> holdOff);
  assert_arm_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    armClr |=> !armed);
endmodule

// File: rtl/dmaSequencer.sv
module dmaSequencer
  import dmaSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              armSet,
  input  logic              armClr,
  input  logic [MODE_W-1:0] xferMode,
  input  logic              memToMem,
  input  logic              devReq,
  input  logic              busGrant,
  input  logic              ready,
  input  logic              termCount,
  output logic              busReq,
  output logic              devAck,
  output logic              chanArmed,
  output logic              writePhase,
  output logic [STATE_W-1:0] stateCode
);
  seqState_e  state;
  seqStrobe_t strobe;
  logic armed, holdOff, inWrite;

  dmaSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferMode(xferMode), .memToMem(memToMem),
    .devReq(devReq), .busGrant(busGrant), .ready(ready), .termCount(termCount),
    .armed(armed), .holdOff(holdOff), .inWrite(inWrite),
    .state(state), .strobe(strobe), .busReq(busReq), .devAck(devAck)
  );

  dmaSeqData u_data (
    .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr), .devReq(devReq),
    .strobe(strobe), .armed(armed), .holdOff(holdOff), .inWrite(inWrite)
  );

  assign chanArmed  = armed;
  assign writePhase = inWrite;
  assign stateCode  = state;

  assert_block_disarm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S4 && xferMode == MODE_BLOCK && termCount && !armSet &&
     (!memToMem || inWrite)) |=> (!chanArmed && !busReq));
  assert_demand_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S4 && xferMode == MODE_DEMAND && !devReq &&
     (!memToMem || inWrite)) |=> !busReq);
  assert_twopass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_S4 && memToMem && !inWrite) |=> (inWrite && state == ST_S1));
endmodule

// File: tb/dmaSequencer_bench.sv
module dmaSequencer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armSet = 1'b0, armClr = 1'b0, memToMem = 1'b0;
  logic devReq = 1'b0, busGrant = 1'b0, ready = 1'b1, termCount = 1'b0;
  logic [1:0] xferMode = 2'd0;
  logic busReq, devAck, chanArmed, writePhase;
  logic [2:0] stateCode;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  dmaSequencer u_dmaSequencer (
    .clk(clk), .rstN(rstN), .armSet(armSet), .armClr(armClr), .xferMode(xferMode),
    .memToMem(memToMem), .devReq(devReq), .busGrant(busGrant), .ready(ready),
    .termCount(termCount), .busReq(busReq), .devAck(devAck), .chanArmed(chanArmed),
    .writePhase(writePhase), .stateCode(stateCode)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseArm(input bit setIt);
    @(negedge clk);
    if (setIt) armSet = 1'b1; else armClr = 1'b1;
    @(negedge clk);
    armSet = 1'b0;
    armClr = 1'b0;
  endtask

  // Follows one bus tenure; inputs set on falling edges for the next rising edge.
  task automatic runTenure(input int tcAt, input int dropAt, input int waits,
                           output int ackCyc, output int wrCyc);
    int s4 = 0;
    int left = 0;
    bit seenBus = 1'b0;
    ackCyc = 0;
    wrCyc = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busReq) seenBus = 1'b1;
      if (seenBus && !busReq) break;
      if (devAck) ackCyc++;
      if (writePhase) wrCyc++;
      if (stateCode == 3'd2) left = waits;
      if (stateCode == 3'd6) s4++;
      termCount = (tcAt > 0 && stateCode == 3'd6 && s4 == tcAt);
      if (dropAt > 0 && stateCode == 3'd6 && s4 == dropAt) devReq = 1'b0;
      if ((stateCode == 3'd4 || stateCode == 3'd5) && left > 0) begin
        ready = 1'b0;
        left--;
      end else ready = 1'b1;
    end
    termCount = 1'b0;
    ready = 1'b1;
  endtask

  task automatic testReset();
    check("R1 reset stateCode", stateCode, 0);
    check("R1 reset busReq", busReq, 0);
    check("R10 reset chanArmed", chanArmed, 0);
  endtask

  task automatic testDisarmed();
    devReq = 1'b1;
    idle(5);
    check("R10 disarmed ignores devReq busReq", busReq, 0);
    check("R1 disarmed stateCode", stateCode, 0);
    devReq = 1'b0;
    pulseArm(1'b1);
    check("R10 armSet arms", chanArmed, 1);
    idle(4);
    check("R1 armed without request busReq", busReq, 0);
  endtask

  task automatic testSingle();
    int ack, wr;
    xferMode = 2'd0;
    busGrant = 1'b0;
    devReq = 1'b1;
    @(negedge clk);
    check("R2 hold state after request", stateCode, 1);
    check("R2 busReq raised", busReq, 1);
    idle(3);
    check("R2 still holding without grant", stateCode, 1);
    check("R2 devAck low before grant", devAck, 0);
    busGrant = 1'b1;
    runTenure(0, 0, 0, ack, wr);
    check("R3 single transfer devAck cycles", ack, 4);
    idle(4);
    check("R5 no rearbitration while devReq held", busReq, 0);
    devReq = 1'b0;
    @(negedge clk);
    devReq = 1'b1;
    @(negedge clk);
    check("R5 new request edge rearbitrates", busReq, 1);
    runTenure(0, 0, 0, ack, wr);
    check("R5 second single transfer cycles", ack, 4);
    devReq = 1'b0;
    idle(2);
  endtask

  task automatic testWaits();
    int ack, wr;
    xferMode = 2'd3;
    devReq = 1'b1;
    runTenure(0, 0, 3, ack, wr);
    check("R4 three wait states stretch devAck", ack, 7);
    devReq = 1'b0;
    idle(2);
  endtask

  task automatic testBlock();
    int ack, wr;
    xferMode = 2'd1;
    devReq = 1'b1;
    runTenure(3, 1, 0, ack, wr);
    check("R6 block three transfers with devReq dropped", ack, 12);
    check("R7 terminal count disarms", chanArmed, 0);
    devReq = 1'b1;
    idle(3);
    check("R7 disarmed after block ignores request", busReq, 0);
    devReq = 1'b0;
    pulseArm(1'b1);
  endtask

  task automatic testDemand();
    int ack, wr;
    xferMode = 2'd2;
    devReq = 1'b1;
    runTenure(0, 3, 0, ack, wr);
    check("R8 demand ends on devReq low", ack, 12);
    check("R8 demand keeps chanArmed", chanArmed, 1);
    devReq = 1'b1;
    runTenure(2, 0, 0, ack, wr);
    check("R8 demand ends on terminal count", ack, 8);
    check("R8 chanArmed after demand count", chanArmed, 1);
    devReq = 1'b0;
    idle(2);
  endtask

  task automatic testMemToMem();
    int ack, wr;
    xferMode = 2'd0;
    memToMem = 1'b1;
    devReq = 1'b1;
    runTenure(0, 0, 0, ack, wr);
    check("R9 two-pass devAck cycles", ack, 8);
    check("R9 writePhase cycles", wr, 4);
    devReq = 1'b0;
    idle(2);
    devReq = 1'b1;
    runTenure(0, 0, 1, ack, wr);
    check("R9 R4 two-pass with one wait per pass", ack, 10);
    devReq = 1'b0;
    memToMem = 1'b0;
    idle(2);
  endtask

  task automatic testArmPriority();
    @(negedge clk);
    armSet = 1'b1;
    armClr = 1'b1;
    @(negedge clk);
    armSet = 1'b0;
    armClr = 1'b0;
    check("R10 armClr wins over armSet", chanArmed, 0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisarmed();
    testSingle();
    testWaits();
    testBlock();
    testDemand();
    testMemToMem();
    testArmPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule